// File: doc/BRIEF.md
# Banked Stack Pointer Control Register File

This block holds the control registers of a small processor core and sits next to a 16-entry general register file. The general register at the top index (register 15) is always the live stack pointer. The core keeps two stack pointers: an interrupt stack pointer and a user stack pointer. Whichever one is not active waits in a shadow control register. A stack-mode flag in the status word selects which one is live.

The control port takes a 3-bit index and 32-bit data. It reads combinationally and writes on the clock edge. The status word packs six single-bit flags. When a status-word write changes the stack-mode flag, the block exchanges register 15 with the correct shadow in the same edge. Accesses to the two stack-pointer control registers follow the mode: the register that is currently live is served from register 15, and the inactive one is served from its shadow. A separate port reads and writes the general registers. When both ports try to write register 15 in the same cycle, the control path wins.

Top module: `sbr_top`

## Requirements
- R1: Control index 0 reads the status word with backup stack mode in bit 15, backup interrupt enable in bit 14, backup condition in bit 8, stack mode (SM) in bit 7, interrupt enable in bit 6 and the condition flag in bit 0. All other bits read zero. A write to index 0 loads all six flags from those bit positions, and the new values are readable in the next cycle.
- R2: Control index 1 reads the condition flag in bit 0 with all other bits zero. A write to index 1 changes only the condition flag, which it takes from write-data bit 0.
- R3: Control index 2 (interrupt stack pointer) is read and written through general register 15 when SM is 0. When SM is 1 it is read and written in its own shadow storage.
- R4: Control index 3 (user stack pointer) is read and written through general register 15 when SM is 1. When SM is 0 it is read and written in its own shadow storage.
- R5: If a status-word write changes SM from 0 to 1, the old register 15 goes to the index-2 shadow and register 15 takes the old index-3 shadow. If it changes SM from 1 to 0, the old register 15 goes to the index-3 shadow and register 15 takes the old index-2 shadow. Both moves happen on the same edge.
- R6: A status-word write that leaves SM unchanged leaves register 15 and both shadows unchanged.
- R7: Control indices 4, 5 and 6 are plain 32-bit storage that read back the last value written to them. Index 6 is the backup PC.
- R8: Control index 7 reads zero. A write to it changes no control register and no general register.
- R9: When a control write targets register 15 (a stack swap, or a redirected index-2 or index-3 write) in the same cycle as a general-register write to index 15, the control write takes effect and the general write is dropped. A general write to any other index in that cycle still takes effect.
- R10: While rst_ni is low, all flags (so SM is 0), all control storage and all general registers are zero.
- R11: A general write stores gr_wdata_i at gr_idx_i on the clock edge. gr_rdata_o shows the register at gr_idx_i combinationally, and index 15 shows the live stack pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cr_we_i | input | 1 | Control register write enable |
| cr_idx_i | input | 3 | Control register index for read and write |
| cr_wdata_i | input | 32 | Control register write data |
| cr_rdata_o | output | 32 | Control register read data (combinational) |
| gr_we_i | input | 1 | General register write enable |
| gr_idx_i | input | 4 | General register index for read and write |
| gr_wdata_i | input | 32 | General register write data |
| gr_rdata_o | output | 32 | General register read data (combinational) |

## Verification
The bench writes all 64 flag patterns into the status word, with junk in the reserved bits. Before each pattern it loads fresh values into both stack pointers, so every SM transition is exercised, as is every write that leaves SM unchanged. A design that skips the save half of a swap would lose the outgoing pointer. A design that does the moves in the wrong order would load register 15 with its own value, and one that swaps on every status write would scramble the pointers when SM is unchanged; each of these shows up on the next index-2, index-3 or register-15 read. Collisions between the two write ports on register 15 are driven both with a swap and with a redirected pointer write, and an independent general write is placed alongside to show it still takes effect. Writes to index 7 and to the condition-only index are followed by a full read-back, which exposes any decode that leaks into a neighbouring register or flag.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned CR_IDX_W = 3;

  localparam int unsigned BSM_BIT   = 15;
  localparam int unsigned BIE_BIT   = 14;
  localparam int unsigned BCOND_BIT = 8;
  localparam int unsigned SM_BIT    = 7;
  localparam int unsigned IE_BIT    = 6;
  localparam int unsigned COND_BIT  = 0;
  localparam int unsigned PSW_W     = BSM_BIT + 1;

  typedef enum logic [CR_IDX_W-1:0] {
    CR_PSW  = 3'd0,
    CR_CBIT = 3'd1,
    CR_ISP  = 3'd2,
    CR_USP  = 3'd3,
    CR_AUX0 = 3'd4,
    CR_AUX1 = 3'd5,
    CR_BPC  = 3'd6,
    CR_NULL = 3'd7
  } cr_sel_e;

  localparam int unsigned AUX_BASE = 4;
  localparam int unsigned AUX_N    = 3;

  typedef struct packed {
    logic bsm;
    logic bie;
    logic bcond;
    logic sm;
    logic ie;
    logic cond;
  } flags_t;

  function automatic logic [PSW_W-1:0] pack_flags(flags_t f);
    logic [PSW_W-1:0] w;
    w            = '0;
    w[BSM_BIT]   = f.bsm;
    w[BIE_BIT]   = f.bie;
    w[BCOND_BIT] = f.bcond;
    w[SM_BIT]    = f.sm;
    w[IE_BIT]    = f.ie;
    w[COND_BIT]  = f.cond;
    return w;
  endfunction
endpackage

// File: rtl/sbr_flags.sv
module sbr_flags
  import sbr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   psw_we_i,
  input  flags_t psw_new_i,
  input  logic   cond_we_i,
  input  logic   cond_i,
  output flags_t flags_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (psw_we_i) begin
      flags_q <= psw_new_i;
    end else if (cond_we_i) begin
      flags_q.cond <= cond_i;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/sbr_gpr.sv
module sbr_gpr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned GR_N   = 16,
  localparam int unsigned IDX_W = $clog2(GR_N),
  localparam int unsigned SP_IDX = GR_N - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] sp_o
);
  logic [DATA_W-1:0] regs [GR_N];

  for (genvar g = 0; g < GR_N; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              port_hit;
    assign port_hit = wr_en_i && (idx_i == IDX_W'(g));

    if (g == SP_IDX) begin : g_sp
      // control-side writes override the general port
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (sp_we_i)  q <= sp_wdata_i;
        else if (port_hit) q <= wr_data_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= '0;
        else if (port_hit) q <= wr_data_i;
      end
    end
    assign regs[g] = q;
  end

  assign rd_data_o = regs[idx_i];
  assign sp_o      = regs[SP_IDX];
endmodule

// File: rtl/sbr_shadow.sv
module sbr_shadow #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AUX_N  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              isp_we_i,
  input  logic [DATA_W-1:0] isp_wdata_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] usp_wdata_i,
  input  logic [AUX_N-1:0]  aux_we_i,
  input  logic [DATA_W-1:0] aux_wdata_i,
  output logic [DATA_W-1:0] isp_o,
  output logic [DATA_W-1:0] usp_o,
  output logic [DATA_W-1:0] aux_o [AUX_N]
);
  logic [DATA_W-1:0] isp_q, usp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      if (isp_we_i) isp_q <= isp_wdata_i;
      if (usp_we_i) usp_q <= usp_wdata_i;
    end
  end

  for (genvar k = 0; k < AUX_N; k++) begin : g_aux
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (aux_we_i[k]) q <= aux_wdata_i;
    end
    assign aux_o[k] = q;
  end

  assign isp_o = isp_q;
  assign usp_o = usp_q;
endmodule

// File: rtl/sbr_top.sv
module sbr_top
  import sbr_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN,
  parameter int unsigned GR_N   = 16,
  localparam int unsigned GR_IDX_W  = $clog2(GR_N),
  localparam int unsigned AUX_IDX_W = $clog2(AUX_N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cr_we_i,
  input  logic [CR_IDX_W-1:0] cr_idx_i,
  input  logic [DATA_W-1:0]   cr_wdata_i,
  output logic [DATA_W-1:0]   cr_rdata_o,
  input  logic                gr_we_i,
  input  logic [GR_IDX_W-1:0] gr_idx_i,
  input  logic [DATA_W-1:0]   gr_wdata_i,
  output logic [DATA_W-1:0]   gr_rdata_o
);
  flags_t            flags, psw_new;
  logic              sm;
  logic [DATA_W-1:0] sp, isp, usp;
  logic [DATA_W-1:0] aux [AUX_N];

  logic psw_we, cbit_we, isp_acc, usp_acc;
  logic swap_up, swap_dn;
  logic sp_we, isp_we, usp_we;
  logic [DATA_W-1:0] sp_wdata, isp_wdata, usp_wdata;
  logic [AUX_N-1:0]  aux_we;
  logic              aux_hit;
  logic [AUX_IDX_W-1:0] aux_sel;

  assign sm      = flags.sm;
  assign psw_we  = cr_we_i && (cr_idx_i == CR_PSW);
  assign cbit_we = cr_we_i && (cr_idx_i == CR_CBIT);
  assign isp_acc = cr_we_i && (cr_idx_i == CR_ISP);
  assign usp_acc = cr_we_i && (cr_idx_i == CR_USP);

  assign psw_new = '{bsm:   cr_wdata_i[BSM_BIT],
                     bie:   cr_wdata_i[BIE_BIT],
                     bcond: cr_wdata_i[BCOND_BIT],
                     sm:    cr_wdata_i[SM_BIT],
                     ie:    cr_wdata_i[IE_BIT],
                     cond:  cr_wdata_i[COND_BIT]};

  assign swap_up = psw_we && !sm &&  psw_new.sm;
  assign swap_dn = psw_we &&  sm && !psw_new.sm;

  // live register 15 side
  assign sp_we    = swap_up || swap_dn || (isp_acc && !sm) || (usp_acc && sm);
  assign sp_wdata = swap_up ? usp : (swap_dn ? isp : cr_wdata_i);

  // shadow side: save outgoing pointer or take a banked write
  assign isp_we    = swap_up || (isp_acc && sm);
  assign isp_wdata = swap_up ? sp : cr_wdata_i;
  assign usp_we    = swap_dn || (usp_acc && !sm);
  assign usp_wdata = swap_dn ? sp : cr_wdata_i;

  for (genvar k = 0; k < AUX_N; k++) begin : g_aux_we
    assign aux_we[k] = cr_we_i && (cr_idx_i == CR_IDX_W'(AUX_BASE + k));
  end

  sbr_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psw_we_i  (psw_we),
    .psw_new_i (psw_new),
    .cond_we_i (cbit_we),
    .cond_i    (cr_wdata_i[COND_BIT]),
    .flags_o   (flags)
  );

  sbr_gpr #(.DATA_W(DATA_W), .GR_N(GR_N)) u_gpr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (gr_we_i),
    .idx_i      (gr_idx_i),
    .wr_data_i  (gr_wdata_i),
    .sp_we_i    (sp_we),
    .sp_wdata_i (sp_wdata),
    .rd_data_o  (gr_rdata_o),
    .sp_o       (sp)
  );

  sbr_shadow #(.DATA_W(DATA_W), .AUX_N(AUX_N)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .isp_we_i    (isp_we),
    .isp_wdata_i (isp_wdata),
    .usp_we_i    (usp_we),
    .usp_wdata_i (usp_wdata),
    .aux_we_i    (aux_we),
    .aux_wdata_i (cr_wdata_i),
    .isp_o       (isp),
    .usp_o       (usp),
    .aux_o       (aux)
  );

  assign aux_hit = (cr_idx_i >= CR_IDX_W'(AUX_BASE)) &&
                   (cr_idx_i <  CR_IDX_W'(AUX_BASE + AUX_N));
  assign aux_sel = AUX_IDX_W'(cr_idx_i - CR_IDX_W'(AUX_BASE));

  always_comb begin
    cr_rdata_o = '0;
    case (cr_idx_i)
      CR_PSW:  cr_rdata_o = DATA_W'(pack_flags(flags));
      CR_CBIT: cr_rdata_o = DATA_W'(flags.cond);
      CR_ISP:  cr_rdata_o = sm ? isp : sp;
      CR_USP:  cr_rdata_o = sm ? sp : usp;
      default: cr_rdata_o = aux_hit ? aux[aux_sel] : '0;
    endcase
  end
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
  import sbr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GR_IDX_W = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cr_we_i,
  input logic [CR_IDX_W-1:0] cr_idx_i,
  input logic [DATA_W-1:0]   cr_wdata_i,
  input logic [DATA_W-1:0]   cr_rdata_o,
  input logic                gr_we_i,
  input logic [GR_IDX_W-1:0] gr_idx_i,
  input logic [DATA_W-1:0]   sp_i,
  input logic [DATA_W-1:0]   isp_i,
  input logic [DATA_W-1:0]   usp_i,
  input logic                sm_i
);
  localparam logic [DATA_W-1:0] PSW_MASK = DATA_W'(pack_flags('1));
  localparam logic [GR_IDX_W-1:0] SP_GR = '1;

  logic psw_wr, gr_sp_wr;
  assign psw_wr   = cr_we_i && (cr_idx_i == CR_PSW);
  assign gr_sp_wr = gr_we_i && (gr_idx_i == SP_GR);

  AST_PSW_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_idx_i == CR_PSW) |-> ((cr_rdata_o & ~PSW_MASK) == '0)); // R1

  AST_CBIT_ONLY_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_idx_i == CR_CBIT) |-> (cr_rdata_o[DATA_W-1:1] == '0)); // R2

  AST_ISP_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_i && cr_idx_i == CR_ISP && !sm_i) |=> (sp_i == $past(cr_wdata_i)) && $stable(isp_i)); // R3

  AST_USP_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_i && cr_idx_i == CR_USP && sm_i) |=> (sp_i == $past(cr_wdata_i)) && $stable(usp_i)); // R4

  AST_SWAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_wr && !sm_i && cr_wdata_i[SM_BIT]) |=>
      (sp_i == $past(usp_i)) && (isp_i == $past(sp_i)) && $stable(usp_i)); // R5

  AST_SWAP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_wr && sm_i && !cr_wdata_i[SM_BIT]) |=>
      (sp_i == $past(isp_i)) && (usp_i == $past(sp_i)) && $stable(isp_i)); // R5

  AST_NO_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_wr && (sm_i == cr_wdata_i[SM_BIT]) && !gr_sp_wr) |=>
      $stable(sp_i) && $stable(isp_i) && $stable(usp_i)); // R6

  AST_NULL_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_idx_i == CR_NULL) |-> (cr_rdata_o == '0)); // R8

  AST_SWAP_BEATS_GR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psw_wr && (sm_i != cr_wdata_i[SM_BIT]) && gr_sp_wr) |=>
      (sp_i == (sm_i ? $past(usp_i) : $past(isp_i)))); // R9
endmodule

bind sbr_top sbr_checker #(.DATA_W(DATA_W), .GR_IDX_W(GR_IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cr_we_i    (cr_we_i),
  .cr_idx_i   (cr_idx_i),
  .cr_wdata_i (cr_wdata_i),
  .cr_rdata_o (cr_rdata_o),
  .gr_we_i    (gr_we_i),
  .gr_idx_i   (gr_idx_i),
  .sp_i       (sp),
  .isp_i      (isp),
  .usp_i      (usp),
  .sm_i       (sm)
);

// File: tb/sbr_top_test.sv
module sbr_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PSW_MASK = 32'h0000_C1C1;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        cr_we_i;
  logic [2:0]  cr_idx_i;
  logic [31:0] cr_wdata_i;
  logic [31:0] cr_rdata_o;
  logic        gr_we_i;
  logic [3:0]  gr_idx_i;
  logic [31:0] gr_wdata_i;
  logic [31:0] gr_rdata_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbr_top uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cr_we_i(cr_we_i), .cr_idx_i(cr_idx_i), .cr_wdata_i(cr_wdata_i), .cr_rdata_o(cr_rdata_o),
    .gr_we_i(gr_we_i), .gr_idx_i(gr_idx_i), .gr_wdata_i(gr_wdata_i), .gr_rdata_o(gr_rdata_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_gr [16];
  logic [31:0] m_isp, m_usp, m_psw;
  logic [31:0] m_aux [3];

  task automatic m_reset();
    for (int i = 0; i < 16; i++) m_gr[i] = '0;
    for (int i = 0; i < 3; i++) m_aux[i] = '0;
    m_isp = '0; m_usp = '0; m_psw = '0;
  endtask

  function automatic logic [31:0] exp_cr(int idx);
    case (idx)
      0: return m_psw;
      1: return {31'b0, m_psw[0]};
      2: return m_psw[7] ? m_isp : m_gr[15];
      3: return m_psw[7] ? m_gr[15] : m_usp;
      4, 5, 6: return m_aux[idx-4];
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_cr(int idx, string tag);
    cr_idx_i = idx[2:0];
    #1;
    check(tag, cr_rdata_o, exp_cr(idx));
  endtask

  task automatic chk_gr(int idx, string tag);
    gr_idx_i = idx[3:0];
    #1;
    check(tag, gr_rdata_o, m_gr[idx]);
  endtask

  task automatic chk_all_cr(string tag);
    for (int i = 0; i < 8; i++) chk_cr(i, tag);
  endtask

  task automatic cyc(bit cwe, int cidx, logic [31:0] cwd, bit gwe, int gidx, logic [31:0] gwd);
    logic [31:0] o_sp, o_isp, o_usp;
    logic        o_sm;
    @(negedge clk);
    cr_we_i = cwe; cr_idx_i = cidx[2:0]; cr_wdata_i = cwd;
    gr_we_i = gwe; gr_idx_i = gidx[3:0]; gr_wdata_i = gwd;
    @(posedge clk);
    #1;
    cr_we_i = 1'b0; gr_we_i = 1'b0;
    o_sp = m_gr[15]; o_isp = m_isp; o_usp = m_usp; o_sm = m_psw[7];
    if (gwe) m_gr[gidx] = gwd;
    if (cwe) begin
      case (cidx)
        0: begin
          m_psw = cwd & PSW_MASK;
          if (!o_sm && cwd[7]) begin m_isp = o_sp; m_gr[15] = o_usp; end
          if (o_sm && !cwd[7]) begin m_usp = o_sp; m_gr[15] = o_isp; end
        end
        1: m_psw[0] = cwd[0];
        2: if (!o_sm) m_gr[15] = cwd; else m_isp = cwd;
        3: if (o_sm) m_gr[15] = cwd; else m_usp = cwd;
        4, 5, 6: m_aux[cidx-4] = cwd;
        default: ;
      endcase
    end
  endtask

  function automatic logic [31:0] flag_word(int v);
    return (32'(v[5]) << 15) | (32'(v[4]) << 14) | (32'(v[3]) << 8) |
           (32'(v[2]) << 7)  | (32'(v[1]) << 6)  | 32'(v[0]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    cr_we_i = 0; cr_idx_i = 0; cr_wdata_i = 0;
    gr_we_i = 0; gr_idx_i = 0; gr_wdata_i = 0;
    m_reset();
    repeat (3) @(posedge clk);
    #2;
    chk_all_cr("R10");
    for (int i = 0; i < 16; i++) chk_gr(i, "R10");
    @(negedge clk);
    rst_ni = 1'b1;

    // general register sweep
    for (int i = 0; i < 16; i++)
      cyc(0, 0, 0, 1, i, 32'h1000_0000 + 32'h0101_0101 * i);
    for (int i = 0; i < 16; i++) chk_gr(i, "R11");

    // stack pointer routing with SM=0
    cyc(1, 2, 32'hA000_0002, 0, 0, 0);
    chk_gr(15, "R3"); chk_cr(2, "R3");
    cyc(1, 3, 32'hB000_0003, 0, 0, 0);
    chk_cr(3, "R4"); chk_gr(15, "R4");

    // plain storage
    for (int i = 4; i < 7; i++) cyc(1, i, 32'hC0DE_0000 + i, 0, 0, 0);
    for (int i = 4; i < 7; i++) chk_cr(i, "R7");

    // null index
    cyc(1, 7, 32'hFFFF_FFFF, 0, 0, 0);
    chk_all_cr("R8");
    for (int i = 0; i < 16; i++) chk_gr(i, "R8");

    // all flag patterns, fresh pointers before each
    for (int v = 0; v < 64; v++) begin
      logic sm_before;
      cyc(1, 2, 32'h2000_0000 + v, 0, 0, 0);
      cyc(1, 3, 32'h3000_0000 + v, 0, 0, 0);
      sm_before = m_psw[7];
      cyc(1, 0, flag_word(v) | (32'h5A5A_3E3E & ~PSW_MASK), 0, 0, 0);
      chk_cr(0, "R1");
      if (sm_before != m_psw[7]) begin
        chk_gr(15, "R5"); chk_cr(2, "R5"); chk_cr(3, "R5");
      end else begin
        chk_gr(15, "R6"); chk_cr(2, "R6"); chk_cr(3, "R6");
      end
      chk_cr(1, "R2");
    end

    // condition-only write, both SM states
    for (int s = 0; s < 2; s++) begin
      cyc(1, 0, flag_word(s ? 6'h3E : 6'h3A), 0, 0, 0);
      cyc(1, 1, 32'hFFFF_FFFF, 0, 0, 0);
      chk_all_cr("R2");
      cyc(1, 1, 32'hFFFF_FFFE, 0, 0, 0);
      chk_all_cr("R2");
      // SM=1 routing
      if (s == 1) begin
        cyc(1, 2, 32'hD000_0002, 0, 0, 0);
        chk_cr(2, "R3"); chk_gr(15, "R3");
        cyc(1, 3, 32'hD000_0003, 0, 0, 0);
        chk_gr(15, "R4"); chk_cr(3, "R4");
      end
    end

    // write-port collisions on register 15
    cyc(1, 0, 32'h0, 0, 0, 0);
    cyc(1, 2, 32'hE000_0002, 0, 0, 0);
    cyc(1, 3, 32'hE000_0003, 0, 0, 0);
    cyc(1, 0, flag_word(6'h04), 1, 15, 32'hDEAD_0015);
    chk_gr(15, "R9"); chk_cr(2, "R9");
    cyc(1, 0, flag_word(6'h00), 1, 15, 32'hDEAD_0016);
    chk_gr(15, "R9"); chk_cr(3, "R9");
    cyc(1, 2, 32'hF000_0002, 1, 15, 32'hDEAD_0017);
    chk_gr(15, "R9");
    cyc(1, 0, flag_word(6'h04), 1, 5, 32'h5555_0005);
    chk_gr(5, "R9"); chk_gr(15, "R9");
    cyc(1, 0, flag_word(6'h05), 1, 15, 32'h7777_0015);
    chk_gr(15, "R6");

    // asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    m_reset();
    #2;
    chk_all_cr("R10");
    for (int i = 0; i < 16; i++) chk_gr(i, "R10");
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule